// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Group

This block holds four 31-bit down-counters that share one time base. Each counter loads a base count, steps down by one on every enabled tick, and when a step finds it at zero it reloads the base count and raises a one-cycle interrupt request. The shared tick is either every cycle of the block clock or one cycle per rising edge of a slow real-time-clock input. The slow input is brought into the block clock domain by a two-stage synchroniser followed by an edge detector. A group-wide select pin picks between the two time bases.

Any timer after the first can be linked to its lower neighbour. A linked timer ignores the shared tick and steps only when its neighbour reloads, so a chain of two timers with base counts A and C fires every (A+1)(C+1) ticks. Software controls each timer through a small register window. It starts and stops a timer with an inhibit bit that is written together with the base count. A read of the current count carries a flag bit that flips on every reload, so polling software can tell that a wrap has occurred.

Top module: `cascade_timer_group`

## Requirements
- R1: After reset every timer is inhibited, with base count 0, current count 0, wrap flag 0 and link bit 0, and every request output is low.
- R2: With rtcSelect low, after the base write that clears inhibit, a timer with base count B first raises its request B+1 clock edges after the write edge, and then again every B+1 cycles.
- R3: A request stays high for exactly one cycle when B is at least 1, and only the timer that reloaded raises its output.
- R4: Field 1 reads the current count in bits 30:0 and the wrap flag in bit 31. While a request is high, the count equals the base. The flag inverts on every reload.
- R5: A base write with bit 31 set sets inhibit and copies bits 30:0 into the current count. An inhibited timer holds its count and raises no request.
- R6: A base write with bit 31 clear clears inhibit and updates the base count, and leaves the current count unchanged. Counting resumes from the held value K, so the first request comes K+1 cycles later.
- R7: Bit 0 of field 2 links timer i (i of 1 or more) to timer i-1. A linked timer does not step on the shared tick and steps only on timer i-1's reload. Its period is (A+1)(C+1) and its request coincides with timer i-1's request. Field 2 of timer 0 always reads 0.
- R8: With rtcSelect high, the shared tick fires once per rising edge of rtcIn after the synchroniser, giving a period of (B+1) times the rtcIn period. While rtcIn is held constant, no timer steps.
- R9: A register address is {timer index, 2-bit field}. Field 0 reads {inhibit, base count}, field 1 and field 2 are as above, and field 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtcSelect | input | 1 | 1: tick from rtcIn rising edges, 0: tick every cycle |
| rtcIn | input | 1 | Slow real-time-clock input, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address {timer, field} |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Read address {timer, field} |
| rdData | output | 32 | Combinational read data |
| irq | output | 4 | One request per timer, one cycle per reload |

## Verification
Every timer is swept over base counts 0 to 3 on the every-cycle tick. The first-request delay separates an off-by-one in the start or reload from a correct period, and the pulse width and the other timers' outputs show whether requests leak between timers. A held count written under inhibit and then released with a different base separates loading the count from loading the base. Linked pairs over several base combinations show whether the downstream timer steps on the reload or on the tick, because only the reload gives the product period. Slow-clock square waves of several periods, and a held level, show whether the edge detector counts edges once, counts levels, or counts both edges.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  parameter int NUM_TMR = 4;
  parameter int CNT_W   = 31;
  localparam int IDX_W  = $clog2(NUM_TMR);
  localparam int FLD_W  = 2;
  localparam int ADDR_W = IDX_W + FLD_W;
  localparam int DATA_W = CNT_W + 1;
  localparam int SYNC_W = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_BASE = 2'd0,
    FLD_CUR  = 2'd1,
    FLD_LINK = 2'd2,
    FLD_RSVD = 2'd3
  } fld_e;

  typedef struct packed {
    logic             baseWr;
    logic             linkWr;
    logic [IDX_W-1:0] sel;
    logic             tick;
  } tmrStrobe_t;
endpackage

// File: rtl/ctg_ctrl.sv
module ctg_ctrl
  import ctg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcSelect,
  input  logic              rtcIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output tmrStrobe_t        strobe
);
  logic [SYNC_W-1:0] rtcPipe;
  logic              rtcRise;
  fld_e              wrFld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtcPipe <= '0;
    else       rtcPipe <= {rtcPipe[SYNC_W-2:0], rtcIn};
  end

  assign rtcRise = rtcPipe[SYNC_W-2] & ~rtcPipe[SYNC_W-1];
  assign wrFld   = fld_e'(wrAddr[FLD_W-1:0]);

  always_comb begin
    strobe.tick   = rtcSelect ? rtcRise : 1'b1;
    strobe.baseWr = wrEn && (wrFld == FLD_BASE);
    strobe.linkWr = wrEn && (wrFld == FLD_LINK);
    strobe.sel    = wrAddr[ADDR_W-1:FLD_W];
  end
endmodule

// File: rtl/ctg_datapath.sv
module ctg_datapath
  import ctg_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  tmrStrobe_t                      strobe,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [ADDR_W-1:0]               rdAddr,
  output logic [DATA_W-1:0]               rdData,
  output logic [NUM_TMR-1:0]              irq,
  output logic [NUM_TMR-1:0]              inhVec,
  output logic [NUM_TMR-1:0]              linkVec,
  output logic [NUM_TMR-1:0]              wrapVec,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   curVec,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   baseVec
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic             hit;
    logic             inh;
    logic             wrap;
    logic             link;
    logic             upReload;
    logic             step;
    logic             reloadNow;
    logic             irqR;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] base;

    assign hit = strobe.sel == IDX_W'(i);

    if (i == 0) begin : g_head
      assign link     = 1'b0;
      assign upReload = 1'b0;
    end else begin : g_linked
      logic linkR;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          linkR <= 1'b0;
        else if (strobe.linkWr && hit)      linkR <= wrData[0];
      end
      assign link     = linkR;
      assign upReload = g_tmr[i-1].reloadNow;
    end

    assign step      = !inh && (link ? upReload : strobe.tick);
    assign reloadNow = step && (cur == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inh  <= 1'b1;
        wrap <= 1'b0;
        cur  <= '0;
        base <= '0;
        irqR <= 1'b0;
      end else begin
        irqR <= reloadNow;
        if (step) begin
          if (reloadNow) begin
            cur  <= base;
            wrap <= ~wrap;
          end else begin
            cur <= cur - 1'b1;
          end
        end
        if (strobe.baseWr && hit) begin
          base <= wrData[CNT_W-1:0];
          inh  <= wrData[CNT_W];
          if (wrData[CNT_W]) cur <= wrData[CNT_W-1:0];
        end
      end
    end

    assign irq[i]     = irqR;
    assign inhVec[i]  = inh;
    assign linkVec[i] = link;
    assign wrapVec[i] = wrap;
    assign curVec[i]  = cur;
    assign baseVec[i] = base;
  end

  logic [IDX_W-1:0] rdTmr;
  fld_e             rdFld;
  assign rdTmr = rdAddr[ADDR_W-1:FLD_W];
  assign rdFld = fld_e'(rdAddr[FLD_W-1:0]);

  always_comb begin
    unique case (rdFld)
      FLD_BASE: rdData = {inhVec[rdTmr], baseVec[rdTmr]};
      FLD_CUR:  rdData = {wrapVec[rdTmr], curVec[rdTmr]};
      FLD_LINK: rdData = {{(DATA_W-1){1'b0}}, linkVec[rdTmr]};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/cascade_timer_group.sv
module cascade_timer_group
  import ctg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcSelect,
  input  logic              rtcIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_TMR-1:0] irq
);
  tmrStrobe_t                    strobe;
  logic [NUM_TMR-1:0]            inhVec;
  logic [NUM_TMR-1:0]            linkVec;
  logic [NUM_TMR-1:0]            wrapVec;
  logic [NUM_TMR-1:0][CNT_W-1:0] curVec;
  logic [NUM_TMR-1:0][CNT_W-1:0] baseVec;

  ctg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rtcSelect (rtcSelect),
    .rtcIn     (rtcIn),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .strobe    (strobe)
  );

  ctg_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .irq     (irq),
    .inhVec  (inhVec),
    .linkVec (linkVec),
    .wrapVec (wrapVec),
    .curVec  (curVec),
    .baseVec (baseVec)
  );
endmodule

// File: rtl/ctg_checker.sv
module ctg_checker
  import ctg_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          rtcSelect,
  input tmrStrobe_t                    strobe,
  input logic [NUM_TMR-1:0]            irq,
  input logic [NUM_TMR-1:0]            inhVec,
  input logic [NUM_TMR-1:0]            linkVec,
  input logic [NUM_TMR-1:0]            wrapVec,
  input logic [NUM_TMR-1:0][CNT_W-1:0] curVec,
  input logic [NUM_TMR-1:0][CNT_W-1:0] baseVec
);
  // R8: an edge-derived tick never lasts two cycles
  a_r8_single_tick: assert property (@(posedge clk) disable iff (!rstN)
    (rtcSelect && strobe.tick) |=> (!strobe.tick || !rtcSelect));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R5: an inhibited timer with no base write keeps its count
    a_r5_inhibit_holds: assert property (@(posedge clk) disable iff (!rstN)
      (inhVec[i] && !(strobe.baseWr && strobe.sel == IDX_W'(i))) |=> $stable(curVec[i]));

    // R4: every request comes with an inverted wrap flag
    a_r4_wrap_flips: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> (wrapVec[i] != $past(wrapVec[i])));

    // R4: while a request is high the count shows the base
    a_r4_reload_to_base: assert property (@(posedge clk) disable iff (!rstN)
      (irq[i] && !$past(strobe.baseWr && strobe.sel == IDX_W'(i))) |-> (curVec[i] == baseVec[i]));

    if (i > 0) begin : g_link
      // R7: a linked timer fires only together with its upstream neighbour
      a_r7_link_sync: assert property (@(posedge clk) disable iff (!rstN)
        ($past(linkVec[i]) && irq[i]) |-> irq[i-1]);
    end
  end
endmodule

bind cascade_timer_group ctg_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rtcSelect (rtcSelect),
  .strobe    (strobe),
  .irq       (irq),
  .inhVec    (inhVec),
  .linkVec   (linkVec),
  .wrapVec   (wrapVec),
  .curVec    (curVec),
  .baseVec   (baseVec)
);

// File: tb/cascade_timer_group_bench.sv
`timescale 1ns/1ps
module cascade_timer_group_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rtcSelect = 1'b0;
  logic        rtcIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;

  int  nChk = 0;
  int  nFail = 0;
  bit  finished = 1'b0;
  bit  genOn = 1'b0;
  localparam logic [31:0] INH = 32'h8000_0000;

  always #4 clk = ~clk;

  cascade_timer_group u_cascade_timer_group (
    .clk(clk), .rstN(rstN), .rtcSelect(rtcSelect), .rtcIn(rtcIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int t, input int f, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = {t[1:0], f[1:0]}; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int t, input int f, output logic [31:0] v);
    rdAddr = {t[1:0], f[1:0]};
    #1;
    v = rdData;
  endtask

  task automatic waitIrq(input int t, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq[t] && n < 3000);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    bit wrapA, seen;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 and R9: reset contents through the register window
    for (int t = 0; t < 4; t++) begin
      rd(t, 0, v); check(v == INH, "R1 base field", v, INH);
      rd(t, 1, v); check(v == 0, "R1 count field", v, 0);
      rd(t, 2, v); check(v == 0, "R1 link field", v, 0);
      rd(t, 3, v); check(v == 0, "R9 reserved field", v, 0);
    end
    check(irq == 0, "R1 irq low", irq, 0);

    // R2, R3, R4: every timer, base 0..3, every-cycle tick
    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < 4; b++) begin
        wr(t, 0, INH | b);
        wr(t, 0, b);
        waitIrq(t, n);
        check(n == b + 1, "R2 first request delay", n, b + 1);
        rd(t, 1, v); wrapA = v[31];
        waitIrq(t, n);
        check(n == b + 1, "R2 period", n, b + 1);
        check((irq & ~(4'b1 << t)) == 0, "R3 other timers quiet", irq, 4'b1 << t);
        rd(t, 1, v);
        check(v[31] != wrapA, "R4 wrap flag flips", v[31], !wrapA);
        check(v[30:0] == b, "R4 count equals base at request", v[30:0], b);
        if (b > 0) begin
          @(negedge clk);
          check(irq[t] == 1'b0, "R3 one-cycle pulse", irq[t], 0);
        end
        wr(t, 0, INH);
      end
    end

    // R5: inhibit write loads the count and freezes the timer
    wr(2, 0, INH | 9);
    wr(2, 0, 9);
    repeat (4) @(negedge clk);
    wr(2, 0, INH | 6);
    rd(2, 1, v); check(v[30:0] == 6, "R5 count loaded", v[30:0], 6);
    seen = 1'b0;
    repeat (25) begin @(negedge clk); if (irq[2]) seen = 1'b1; end
    rd(2, 1, v); check(v[30:0] == 6, "R5 count held", v[30:0], 6);
    check(!seen, "R5 no request while inhibited", seen, 0);

    // R6: release with a new base keeps the held count
    wr(2, 0, 3);
    waitIrq(2, n);
    check(n == 7, "R6 resumes from held count", n, 7);
    rd(2, 0, v); check(v == 3, "R6 base updated inhibit clear", v, 3);
    waitIrq(2, n);
    check(n == 4, "R6 new base period", n, 4);
    wr(2, 0, INH);

    // R7: linking
    wr(0, 2, 1);
    rd(0, 2, v); check(v == 0, "R7 timer 0 link reads 0", v, 0);
    wr(1, 2, 1);
    rd(1, 2, v); check(v == 1, "R7 link bit set", v, 1);
    wr(1, 0, INH | 2);
    wr(1, 0, 2);
    repeat (10) @(negedge clk);
    rd(1, 1, v); check(v[30:0] == 2, "R7 linked timer ignores tick", v[30:0], 2);
    wr(1, 0, INH);
    for (int a = 1; a <= 2; a++) begin
      for (int c = 0; c <= 2; c++) begin
        wr(0, 0, INH | a);
        wr(1, 0, INH | c);
        wr(1, 0, c);
        wr(0, 0, a);
        waitIrq(1, n);
        waitIrq(1, n);
        check(n == (a + 1) * (c + 1), "R7 chained period", n, (a + 1) * (c + 1));
        check(irq[0] == 1'b1, "R7 upstream coincides", irq[0], 1);
        wr(0, 0, INH);
        wr(1, 0, INH);
      end
    end
    wr(1, 2, 0);

    // R8: slow clock as time base
    rtcSelect = 1'b1;
    for (int k = 0; k < 3; k++) begin
      int b, h;
      b = (k == 0) ? 2 : (k == 1) ? 1 : 0;
      h = (k == 0) ? 3 : (k == 1) ? 5 : 2;
      genOn = 1'b1;
      fork
        begin
          while (genOn) begin
            repeat (h) @(negedge clk);
            rtcIn = ~rtcIn;
          end
        end
        begin
          wr(3, 0, INH | b);
          wr(3, 0, b);
          waitIrq(3, n);
          waitIrq(3, n);
          check(n == (b + 1) * 2 * h, "R8 slow tick period", n, (b + 1) * 2 * h);
          genOn = 1'b0;
        end
      join
    end
    repeat (5) @(negedge clk);
    rd(3, 1, v);
    seen = 1'b0;
    repeat (30) begin @(negedge clk); if (irq[3]) seen = 1'b1; end
    rd(3, 1, v2);
    check(v2[30:0] == v[30:0], "R8 held level gives no step", v2[30:0], v[30:0]);
    check(!seen, "R8 held level gives no request", seen, 0);
    rtcSelect = 1'b0;
    wr(3, 0, INH);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule